// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small 16-bit processor core. Its only working register that software can see is the accumulator, which every arithmetic, shift, load and store uses as an implicit operand. Instructions are 16-bit words held in a byte-addressed memory. The core reads and writes that memory through one address bus, one 16-bit data word in each direction and a two-bit command.

A hardwired sequencer carries each instruction through a fetch state, two decode states and one or more execute states, one state per clock. Before every instruction fetch, the address register holds the address of the instruction being fetched and the program counter already holds the address two bytes beyond it. Every execute path re-establishes this condition before it returns to fetch. The core is meant to sit beside a simple word memory whose read data is valid in the same cycle as the address and the read command.

Top module: `acc_core`

## Requirements
- R1: While reset is high and until the first fetch, mem_cmd is idle (00). The accumulator resets to 0. The first read, which comes two cycles after reset is released, is at address 0.
- R2: An instruction word is {flag[15], opcode[14:10], X[9:0]}. The flag in bit 15 is ignored, and every instruction behaves as if X is the operand.
- R3: Opcode 00000 sets AC to AC plus X sign-extended to 16 bits. Opcode 00001 sets AC to the bitwise NAND of AC and the sign-extended X.
- R4: Opcode 00010 shifts AC by one bit. When X bit 0 is 0 the shift is a logical shift left, and when it is 1 the shift is a logical shift right.
- R5: Opcode 00011 loads AC from the memory word at X zero-extended to 16 bits. Bit 9 of X does not produce a negative address.
- R6: Opcode 00100 writes AC to address X zero-extended to 16 bits. The write command lasts exactly one cycle.
- R7: Opcode 00101 continues at address X when AC bit 15 is 1, and at the next sequential instruction otherwise.
- R8: Opcodes 00110 and 00111 continue at address X.
- R9: Sequential instructions sit two bytes apart. In every fetch cycle, the program counter equals the fetch address plus 2.
- R10: Each instruction takes a fixed number of cycles counted from its fetch: 4 for arithmetic, shift, branch and jump, 5 for store and 6 for load.
- R11: The command encoding is 00 idle, 01 read and 10 write, and 11 is never issued. The core captures read data at the end of the cycle in which read is driven.
- R12: Any opcode not listed above leaves AC unchanged, takes 4 cycles and continues at the next sequential instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | DATA_W | Byte address of the current memory access |
| mem_wdata | output | DATA_W | Data word written on a write command (the accumulator) |
| mem_rdata | input | DATA_W | Data word returned by memory on a read command |
| mem_cmd | output | 2 | Memory command: 00 idle, 01 read, 10 write |

## Verification
The main test is a self-modifying loop that sums the even numbers from 2 to 10. It brings together load, store, add, branch and jump, and it only gives 30 if the two-byte PC step and the fetch invariant are right. Random straight-line sequences of add, NAND and shift with random 10-bit immediates tell sign extension apart from zero extension, and a left shift apart from a right one. Directed branches on AC values of 0, 5, 0x7FFF, 0x8000, 0xFFFB and 0xFFFF separate a test of bit 15 from a test against zero. A load from an address with bit 9 set exposes any sign extension on the address path. Measuring the cycle at which the first write appears checks the length of each instruction path.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int OP_W = 5;

  localparam logic [OP_W-1:0] OPC_ADD   = 5'b00000;
  localparam logic [OP_W-1:0] OPC_NAND  = 5'b00001;
  localparam logic [OP_W-1:0] OPC_SHIFT = 5'b00010;
  localparam logic [OP_W-1:0] OPC_LOAD  = 5'b00011;
  localparam logic [OP_W-1:0] OPC_STORE = 5'b00100;
  localparam logic [OP_W-1:0] OPC_BNEG  = 5'b00101;
  localparam logic [OP_W-1:0] OPC_GOTO  = 5'b00110;

  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10
  } mem_cmd_e;

  typedef enum logic [3:0] {
    ST_BOOT0, ST_BOOT1, ST_IFETCH, ST_DEC0, ST_DEC1,
    ST_ARITH, ST_SHIFT, ST_LDA, ST_LDB, ST_LDC,
    ST_STA, ST_STB, ST_GOTO, ST_BNEG, ST_SKIP
  } state_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_NAND, ALU_SHL, ALU_SHR, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {
    EXT_SX = 2'b00,
    EXT_ZX = 2'b01,
    EXT_DI = 2'b10
  } ext_sel_e;

  typedef enum logic [1:0] {
    PC_HOLD, PC_CLEAR, PC_INC, PC_LOAD_INC
  } pc_sel_e;

  typedef enum logic [1:0] {
    AO_HOLD, AO_CLEAR, AO_FROM_PC, AO_FROM_BUS
  } ao_sel_e;

  typedef struct packed {
    logic     di_le;
    logic     ir_le;
    logic     ac_le;
    alu_op_e  alu_op;
    ext_sel_e ext_sel;
    pc_sel_e  pc_sel;
    ao_sel_e  ao_sel;
  } ctrl_t;

endpackage

// File: rtl/acc_operand_ext.sv
module acc_operand_ext
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int X_W    = 10
) (
  input  logic [DATA_W-1:0] di,
  input  ext_sel_e          sel,
  output logic [DATA_W-1:0] y
);
  localparam int PAD_W = DATA_W - X_W;

  always_comb begin
    unique case (sel)
      EXT_SX:  y = {{PAD_W{di[X_W-1]}}, di[X_W-1:0]};
      EXT_ZX:  y = {{PAD_W{1'b0}}, di[X_W-1:0]};
      default: y = di;
    endcase
  end
endmodule

// File: rtl/acc_pc_unit.sv
module acc_pc_unit
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  pc_sel_e           sel,
  input  logic [DATA_W-1:0] abus,
  output logic [DATA_W-1:0] pc
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

  logic [DATA_W-1:0] base;
  assign base = (sel == PC_LOAD_INC) ? abus : pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else begin
      unique case (sel)
        PC_CLEAR:            pc <= '0;
        PC_INC, PC_LOAD_INC: pc <= base + STEP;
        default:             pc <= pc;
      endcase
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  alu_op_e           op,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_NAND: y = ~(a & b);
      ALU_SHL:  y = {a[DATA_W-2:0], 1'b0};
      ALU_SHR:  y = {1'b0, a[DATA_W-1:1]};
      default:  y = b;
    endcase
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_core_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            shift_right,
  input  logic            ac_neg,
  output state_e          state,
  output ctrl_t           ctl,
  output logic [1:0]      mem_cmd
);
  state_e   st_q, nxt;
  mem_cmd_e cmd_q, cmd_d;

  always_comb begin
    nxt         = st_q;
    ctl.di_le   = 1'b0;
    ctl.ir_le   = 1'b0;
    ctl.ac_le   = 1'b0;
    ctl.alu_op  = ALU_PASSB;
    ctl.ext_sel = EXT_ZX;
    ctl.pc_sel  = PC_HOLD;
    ctl.ao_sel  = AO_HOLD;
    unique case (st_q)
      ST_BOOT0: begin
        ctl.pc_sel = PC_CLEAR;
        ctl.ao_sel = AO_CLEAR;
        nxt        = ST_BOOT1;
      end
      ST_BOOT1: begin
        ctl.pc_sel = PC_INC;
        nxt        = ST_IFETCH;
      end
      ST_IFETCH: begin
        ctl.di_le = 1'b1;
        nxt       = ST_DEC0;
      end
      ST_DEC0: begin
        ctl.ir_le = 1'b1;
        nxt       = ST_DEC1;
      end
      ST_DEC1: begin
        ctl.ao_sel = AO_FROM_BUS;
        casez (opcode)
          5'b0000?:  nxt = ST_ARITH;
          OPC_SHIFT: nxt = ST_SHIFT;
          OPC_LOAD:  nxt = ST_LDA;
          OPC_STORE: nxt = ST_STA;
          OPC_BNEG:  nxt = ST_BNEG;
          5'b0011?:  nxt = ST_GOTO;
          default:   nxt = ST_SKIP;
        endcase
      end
      ST_ARITH: begin
        ctl.ext_sel = EXT_SX;
        ctl.alu_op  = opcode[0] ? ALU_NAND : ALU_ADD;
        ctl.ac_le   = 1'b1;
        ctl.ao_sel  = AO_FROM_PC;
        ctl.pc_sel  = PC_INC;
        nxt         = ST_IFETCH;
      end
      ST_SHIFT: begin
        ctl.alu_op = shift_right ? ALU_SHR : ALU_SHL;
        ctl.ac_le  = 1'b1;
        ctl.ao_sel = AO_FROM_PC;
        ctl.pc_sel = PC_INC;
        nxt        = ST_IFETCH;
      end
      ST_LDA: begin
        ctl.di_le = 1'b1;
        nxt       = ST_LDB;
      end
      ST_LDB: begin
        ctl.ext_sel = EXT_DI;
        ctl.ac_le   = 1'b1;
        nxt         = ST_LDC;
      end
      ST_STA: nxt = ST_STB;
      ST_GOTO: begin
        ctl.ao_sel = AO_FROM_BUS;
        ctl.pc_sel = PC_LOAD_INC;
        nxt        = ST_IFETCH;
      end
      ST_BNEG: begin
        ctl.ao_sel = ac_neg ? AO_FROM_BUS : AO_FROM_PC;
        ctl.pc_sel = ac_neg ? PC_LOAD_INC : PC_INC;
        nxt        = ST_IFETCH;
      end
      default: begin
        ctl.ao_sel = AO_FROM_PC;
        ctl.pc_sel = PC_INC;
        nxt        = ST_IFETCH;
      end
    endcase
  end

  always_comb begin
    if (nxt == ST_IFETCH || nxt == ST_LDA) cmd_d = CMD_READ;
    else if (nxt == ST_STA)                cmd_d = CMD_WRITE;
    else                                   cmd_d = CMD_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_BOOT0;
      cmd_q <= CMD_IDLE;
    end else begin
      st_q  <= nxt;
      cmd_q <= cmd_d;
    end
  end

  assign state   = st_q;
  assign mem_cmd = cmd_q;
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [1:0]        mem_cmd
);
  localparam int X_W     = DATA_W - 1 - OP_W;
  localparam int OPC_MSB = DATA_W - 2;

  state_e            state_q;
  ctrl_t             ctl;
  logic [DATA_W-1:0] ao_q, di_q, ac_q, pc, abus, alu_y;
  logic [OP_W-1:0]   ir_q;

  acc_ctrl ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .opcode      (ir_q),
    .shift_right (di_q[0]),
    .ac_neg      (ac_q[DATA_W-1]),
    .state       (state_q),
    .ctl         (ctl),
    .mem_cmd     (mem_cmd)
  );

  acc_operand_ext #(.DATA_W(DATA_W), .X_W(X_W)) ext_i (
    .di  (di_q),
    .sel (ctl.ext_sel),
    .y   (abus)
  );

  acc_pc_unit #(.DATA_W(DATA_W)) pc_i (
    .clk  (clk),
    .rst  (rst),
    .sel  (ctl.pc_sel),
    .abus (abus),
    .pc   (pc)
  );

  acc_alu #(.DATA_W(DATA_W)) alu_i (
    .a  (ac_q),
    .b  (abus),
    .op (ctl.alu_op),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ao_q <= '0;
      di_q <= '0;
      ir_q <= '0;
      ac_q <= '0;
    end else begin
      if (ctl.di_le) di_q <= mem_rdata;
      if (ctl.ir_le) ir_q <= di_q[OPC_MSB -: OP_W];
      if (ctl.ac_le) ac_q <= alu_y;
      unique case (ctl.ao_sel)
        AO_CLEAR:    ao_q <= '0;
        AO_FROM_PC:  ao_q <= pc;
        AO_FROM_BUS: ao_q <= abus;
        default:     ao_q <= ao_q;
      endcase
    end
  end

  assign mem_addr  = ao_q;
  assign mem_wdata = ac_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input state_e            state,
  input logic [1:0]        mem_cmd,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] pc,
  input logic [DATA_W-1:0] ac,
  input logic [DATA_W-1:0] di
);
  localparam int X_W = DATA_W - 1 - OP_W;
  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

  // R9: program counter leads the fetch address by one instruction
  a_r9_fetch_invariant: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IFETCH) |-> (pc == mem_addr + STEP));

  // R11: fetch state always drives a read
  a_r11_fetch_reads: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IFETCH) |-> (mem_cmd == CMD_READ));

  // R11: the unused command code never appears
  a_r11_cmd_legal: assert property (@(posedge clk) disable iff (rst)
    mem_cmd != 2'b11);

  // R6: a write lasts one cycle
  a_r6_write_single: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd == CMD_WRITE) |=> (mem_cmd == CMD_IDLE));

  // R6: store address is the unextended X field
  a_r6_store_addr: assert property (@(posedge clk) disable iff (rst)
    (mem_cmd == CMD_WRITE) |-> (mem_addr == {{(DATA_W-X_W){1'b0}}, di[X_W-1:0]}));

  // R10: fetch always moves to the first decode state
  a_r10_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IFETCH) |=> (state == ST_DEC0));

  // R3: fetch and decode leave the accumulator untouched
  a_r3_ac_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IFETCH || state == ST_DEC0 || state == ST_DEC1) |=> $stable(ac));
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .state    (state_q),
  .mem_cmd  (mem_cmd),
  .mem_addr (mem_addr),
  .pc       (pc),
  .ac       (ac_q),
  .di       (di_q)
);

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 512;
  localparam logic [15:0] RES = 16'h0200;
  localparam logic [4:0] O_ADD = 5'd0, O_NAND = 5'd1, O_SHIFT = 5'd2, O_LOAD = 5'd3,
                         O_STORE = 5'd4, O_BNEG = 5'd5, O_GOTO = 5'd6, O_UNUSED = 5'd8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_cmd;
  logic [15:0] mem [0:MEM_WORDS-1];
  int          tests = 0, fails = 0, cyc = 0;
  bit          done = 1'b0, rd_seen, wr_seen, first_reset = 1'b1;
  int          rd_cyc, wr_cyc;
  logic [15:0] rd_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_core #(.DATA_W(16)) dut_i (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_cmd(mem_cmd)
  );

  assign mem_rdata = (mem_addr < 16'd1024) ? mem[mem_addr[9:1]] : 16'hDEAD;

  always @(posedge clk) begin
    if (mem_cmd == 2'b10 && mem_addr < 16'd1024) mem[mem_addr[9:1]] <= mem_wdata;
    cyc <= rst ? 0 : cyc + 1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_cmd == 2'b01 && !rd_seen) begin rd_seen = 1'b1; rd_cyc = cyc; rd_addr = mem_addr; end
      if (mem_cmd == 2'b10 && !wr_seen) begin wr_seen = 1'b1; wr_cyc = cyc; end
    end
  end

  function automatic logic [15:0] enc(input logic [4:0] opc, input logic [9:0] x);
    return {1'b0, opc, x};
  endfunction

  function automatic logic [15:0] model(input logic [15:0] ac, input logic [15:0] w);
    logic [15:0] sx;
    sx = {{6{w[9]}}, w[9:0]};
    case (w[14:10])
      O_ADD:   return ac + sx;
      O_NAND:  return ~(ac & sx);
      O_SHIFT: return w[0] ? (ac >> 1) : (ac << 1);
      default: return ac;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 16'h0000;
    mem[RES >> 1] = 16'hA5A5;
  endtask

  task automatic put(input int baddr, input logic [15:0] w);
    mem[baddr >> 1] = w;
  endtask

  task automatic start_run(input int ncyc);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    if (first_reset) begin
      check("R1 reset command idle", mem_cmd, 2'b00);
      check("R1 reset address zero", mem_addr, 16'h0000);
      first_reset = 1'b0;
    end
    rd_seen = 1'b0;
    wr_seen = 1'b0;
    rst = 1'b0;
    repeat (ncyc) @(negedge clk);
  endtask

  task automatic branch_case(input string tag, input logic [15:0] p0, p1, p2);
    logic [15:0] ac;
    clear_mem();
    put(0, p0); put(2, p1); put(4, p2);
    put(6, enc(O_BNEG, 10'h040));
    put(8, enc(O_ADD, 10'd100));
    put(10, enc(O_STORE, RES[9:0]));
    put(12, enc(O_GOTO, 10'd12));
    put(16'h40, enc(O_STORE, RES[9:0]));
    put(16'h42, enc(O_GOTO, 10'h042));
    ac = model(model(model(16'h0, p0), p1), p2);
    start_run(80);
    check(tag, mem[RES >> 1], ac[15] ? ac : ac + 16'd100);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp, w, d;
    void'($urandom(32'd20240611));

    // R1 R6 R10: store as first instruction, AC reset value
    clear_mem();
    put(0, enc(O_STORE, RES[9:0])); put(2, enc(O_GOTO, 10'd2));
    start_run(30);
    check("R1 first read cycle", rd_cyc, 2);
    check("R1 first read address", rd_addr, 16'h0000);
    check("R1 accumulator reset to zero", mem[RES >> 1], 16'h0000);
    check("R10 store path cycles", wr_cyc, 5);

    // R3 R10: add then store
    clear_mem();
    put(0, enc(O_ADD, 10'h3F9)); put(2, enc(O_STORE, RES[9:0])); put(4, enc(O_GOTO, 10'd4));
    start_run(40);
    check("R3 add negative immediate", mem[RES >> 1], 16'hFFF9);
    check("R10 arithmetic path cycles", wr_cyc, 9);

    // R5 R10: load with X bit 9 set (zero-extended address)
    clear_mem();
    d = 16'($urandom);
    put(16'h3F0, d);
    put(0, enc(O_LOAD, 10'h3F0)); put(2, enc(O_STORE, 10'h3F2)); put(4, enc(O_GOTO, 10'd4));
    start_run(40);
    check("R5 load zero-extended address", mem[16'h3F2 >> 1], d);
    check("R10 load path cycles", wr_cyc, 11);

    // R8 R10: jump skips the following word
    clear_mem();
    put(0, enc(O_GOTO, 10'h060)); put(2, enc(O_ADD, 10'd1));
    put(16'h60, enc(O_ADD, 10'd9)); put(16'h62, enc(O_STORE, RES[9:0])); put(16'h64, enc(O_GOTO, 10'h064));
    start_run(40);
    check("R8 jump target reached", mem[RES >> 1], 16'd9);
    check("R8 R10 jump then add then store cycles", wr_cyc, 13);

    // R8: second jump opcode code 00111
    clear_mem();
    put(0, enc(5'd7, 10'h050)); put(2, enc(O_ADD, 10'd1)); put(4, enc(O_STORE, RES[9:0]));
    put(16'h50, enc(O_NAND, 10'h000)); put(16'h52, enc(O_STORE, RES[9:0])); put(16'h54, enc(O_GOTO, 10'h054));
    start_run(40);
    check("R8 jump via 00111", mem[RES >> 1], 16'hFFFF);

    // R2: indirect flag ignored
    clear_mem();
    put(0, 16'h8000 | enc(O_ADD, 10'd7)); put(2, enc(O_STORE, RES[9:0])); put(4, enc(O_GOTO, 10'd4));
    start_run(40);
    check("R2 flag bit ignored", mem[RES >> 1], 16'd7);

    // R12: unassigned opcode is a 4-cycle no-op
    clear_mem();
    put(0, enc(O_ADD, 10'd3)); put(2, enc(O_UNUSED, 10'h155));
    put(4, enc(O_STORE, RES[9:0])); put(6, enc(O_GOTO, 10'd6));
    start_run(40);
    check("R12 unassigned opcode keeps AC", mem[RES >> 1], 16'd3);
    check("R12 unassigned opcode cycles", wr_cyc, 13);

    // R4: shift directions
    clear_mem();
    put(0, enc(O_ADD, 10'h201)); put(2, enc(O_SHIFT, 10'd0)); put(4, enc(O_STORE, RES[9:0]));
    put(6, enc(O_SHIFT, 10'd1)); put(8, enc(O_SHIFT, 10'd1)); put(10, enc(O_STORE, 10'h202));
    put(12, enc(O_GOTO, 10'd12));
    start_run(60);
    check("R4 shift left", mem[RES >> 1], 16'hFC02);
    check("R4 shift right logical", mem[16'h202 >> 1], 16'h3F00);

    // R7: branch on bit 15
    branch_case("R7 branch taken on -5", enc(O_ADD, 10'h3FB), 16'h0, 16'h0);
    branch_case("R7 branch not taken on 5", enc(O_ADD, 10'd5), 16'h0, 16'h0);
    branch_case("R7 branch not taken on zero", 16'h0, 16'h0, 16'h0);
    branch_case("R7 branch not taken on 7FFF", enc(O_NAND, 10'd0), enc(O_SHIFT, 10'd1), 16'h0);
    branch_case("R7 branch taken on 8000", enc(O_NAND, 10'd0), enc(O_SHIFT, 10'd1), enc(O_ADD, 10'd1));
    branch_case("R7 branch taken on FFFF", enc(O_NAND, 10'd0), 16'h0, 16'h0);

    // R9: self-modifying sum of even numbers 2..10
    clear_mem();
    put(16'h100, 16'h0000);
    put(0, enc(O_LOAD, 10'h100)); put(2, enc(O_ADD, 10'd2)); put(4, enc(O_STORE, 10'h100));
    put(6, enc(O_LOAD, 10'd2)); put(8, enc(O_ADD, 10'd2)); put(10, enc(O_STORE, 10'd2));
    put(12, enc(O_ADD, 10'h3F4)); put(14, enc(O_BNEG, 10'd0)); put(16, enc(O_GOTO, 10'd16));
    start_run(400);
    check("R9 even sum program result", mem[16'h100 >> 1], 16'd30);

    // R3 R4: random arithmetic and shift sequences
    for (int t = 0; t < 20; t++) begin
      clear_mem();
      exp = 16'h0000;
      for (int k = 0; k < 6; k++) begin
        case ($urandom % 3)
          0: w = enc(O_ADD, 10'($urandom));
          1: w = enc(O_NAND, 10'($urandom));
          default: w = enc(O_SHIFT, 10'($urandom));
        endcase
        put(2 * k, w);
        exp = model(exp, w);
      end
      put(12, enc(O_STORE, RES[9:0])); put(14, enc(O_GOTO, 10'd14));
      start_run(60);
      check("R3 R4 random sequence result", mem[RES >> 1], exp);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule